// File: doc/BRIEF.md
# SDRAM Line Burst Sequencer

This block issues the command stream for moving one 32-byte cache line between a controller and synchronous DRAM over a 64-bit data path. The SDRAM runs with a burst length of 4. A request gives a row, a column whose bits below the line boundary are ignored, the index of the critical 64-bit unit, and a direction flag. The block splits the line into two 16-byte halves. The half that holds the critical unit goes first, using a plain read or write command, and wraps inside that half. The other half follows with the auto-precharge variant of the command and starts at its lowest unit. The block produces the command code, the row and column, a strobe and unit index for each data beat, a one-cycle strobe at the first returned beat of each read command, and an acknowledge that leads the write data.

The state machine has eight states:
- ST_IDLE: ready for a request.
- ST_PREP: the first acknowledge cycle, used on writes only.
- ST_ACT: activate.
- ST_RCD: the RAS-to-CAS wait, used on reads only.
- ST_CMD1: the command for the first half.
- ST_GAP: three NOP cycles.
- ST_CMD2: the auto-precharge command for the second half.
- ST_RECOV: the tail of data beats, write-recovery cycles and precharge wait.

Its transitions are:
- IDLE→PREP when a write request is accepted, and IDLE→ACT when a read request is accepted.
- PREP→ACT.
- ACT→CMD1 on a write or when the RAS-to-CAS field is 0; otherwise ACT→RCD.
- RCD→CMD1 when its count is used up.
- CMD1→GAP, then GAP→CMD2 after three cycles.
- CMD2→RECOV, then RECOV→IDLE when its count is used up.

Top module: `sdr_line_seq`

## Requirements
- R1: After reset and whenever `req_ready` is high, `sd_cmd` is NOP (code 0) and `dack`, `rd_bs`, `wr_beat_valid` and `rd_beat_valid` are low. Command codes are NOP=0, ACT=1, RD=2, RDA=3, WR=4, WRA=5.
- R2: Number the cycles after the accepting clock edge from 0. For a write, cycle 1 is ACT with `sd_row` equal to the request row. Cycle 2 is WR with `sd_col` = {line base, h, c0, 3'b000}, and cycle 6 is WRA with `sd_col` = {line base, ~h, 4'b0000}. Here h and c0 are bits 1 and 0 of `req_crit`, and the line base is `req_col[COL_W-1:5]`. All other cycles are NOP.
- R3: For a write, `wr_beat_valid` is high in cycles 2, 3, 6 and 7, with `wr_beat_unit` equal to {h,c0}, {h,~c0}, {~h,0} and {~h,1} in that order.
- R4: `dack` is high in exactly cycles 0 and 1 of a write, the two cycles before the WR command, and never during a read.
- R5: For a read with RAS-to-CAS field d, cycle 0 is ACT. RD comes at cycle a=d+1 with the first-half column, and RDA comes at a+4 with the second-half column. All other cycles are NOP.
- R6: With `cfg_cl3` selecting a CAS latency L of 2 (0) or 3 (1), `rd_beat_valid` is high in cycles a+L, a+L+1, a+4+L and a+5+L. The units in those cycles are {h,c0}, {h,~c0}, {~h,0} and {~h,1}.
- R7: `rd_bs` is high for exactly one cycle, at the first beat of each read burst (cycles a+L and a+4+L). It is never high on writes.
- R8: After WRA at cycle w, `req_ready` stays low until cycle w+2+N+TRP. N is the 3-bit write-recovery field, so a value of 0 adds no cycles, and TRP is the precharge wait parameter.
- R9: After RDA at cycle r, `req_ready` stays low until cycle r+L+2+TRP.
- R10: While `req_ready` is low, `req_valid` and the request fields have no effect on any output.
- R11: The configuration fields are sampled at acceptance. Changing them during a transfer does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rcd | input | 2 | RAS-to-CAS field; RD is issued cfg_rcd+1 cycles after ACT |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| cfg_trwl | input | 3 | Write-recovery cycles after WRA |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Byte column; bits below the line boundary ignored |
| req_crit | input | 2 | Index of the critical 64-bit unit in the line |
| sd_cmd | output | 3 | Command code (NOP=0, ACT=1, RD=2, RDA=3, WR=4, WRA=5) |
| sd_row | output | ROW_W | Row during ACT, else 0 |
| sd_col | output | COL_W | Column during a read or write command, else 0 |
| dack | output | 1 | Acknowledge leading the write data |
| wr_beat_valid | output | 1 | Write data beat driven this cycle |
| wr_beat_unit | output | 2 | Line unit of the write beat |
| rd_beat_valid | output | 1 | Read data beat to capture this cycle |
| rd_beat_unit | output | 2 | Line unit of the read beat |
| rd_bs | output | 1 | First beat of a read burst |

## Verification
The bench uses the default parameters: 13-bit rows, 12-bit columns, a 64-bit data path and TRP of 2. With these, the configuration space is small enough to cover completely. Every critical-unit position is crossed with all eight write-recovery values for writes. For reads, every critical-unit position is crossed with all four RAS-to-CAS values and both CAS latencies. Every cycle of each transfer is compared with timings computed from these formulas, while the request pins and configuration fields are scrambled during the busy window.

// File: rtl/sdr_line_pkg.sv
package sdr_line_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_WR  = 3'd4,
        CMD_WRA = 3'd5
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ACT,
        ST_RCD,
        ST_CMD1,
        ST_GAP,
        ST_CMD2,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic       v;
        logic       first;
        logic [1:0] unit;
    } beat_t;

    // NOP cycles between the two burst commands (command spacing of 4)
    localparam int unsigned BURST_GAP = 3;

endpackage

// File: rtl/sdr_line_fsm.sv
module sdr_line_fsm
    import sdr_line_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 12,
    parameter int LINE_LSB = 5,
    parameter int TRP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       req_crit,
    input  logic [1:0]       cfg_rcd,
    input  logic             cfg_cl3,
    input  logic [2:0]       cfg_trwl,
    output logic             req_ready,
    output logic [2:0]       cmd,
    output logic [ROW_W-1:0] row_out,
    output logic [COL_W-1:0] col_out,
    output logic             dack,
    output logic             first_cmd,
    output logic             second_cmd,
    output logic             wr_q,
    output logic [1:0]       crit_q,
    output logic             cl3_q
);

    localparam int RECOV_MAX = 7 + TRP + 3;
    localparam int CNT_W = $clog2(RECOV_MAX + 1);
    localparam int BASE_W = COL_W - LINE_LSB;

    seq_state_e st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [ROW_W-1:0] row_q;
    logic [BASE_W-1:0] base_q;
    logic [1:0] rcd_q;
    logic [2:0] trwl_q;
    logic accept;

    assign accept = (st == ST_IDLE) && req_valid;

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            row_q  <= '0;
            base_q <= '0;
            crit_q <= '0;
            rcd_q  <= '0;
            cl3_q  <= 1'b0;
            trwl_q <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (accept) begin
                wr_q   <= req_write;
                row_q  <= req_row;
                base_q <= req_col[COL_W-1:LINE_LSB];
                crit_q <= req_crit;
                rcd_q  <= cfg_rcd;
                cl3_q  <= cfg_cl3;
                trwl_q <= cfg_trwl;
            end
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) st_n = req_write ? ST_PREP : ST_ACT;
            end
            ST_PREP: st_n = ST_ACT;
            ST_ACT: begin
                if (wr_q || rcd_q == 2'd0) begin
                    st_n = ST_CMD1;
                end else begin
                    st_n  = ST_RCD;
                    cnt_n = CNT_W'(rcd_q) - CNT_W'(1);
                end
            end
            ST_RCD: begin
                if (cnt == '0) st_n = ST_CMD1;
                else cnt_n = cnt - CNT_W'(1);
            end
            ST_CMD1: begin
                st_n  = ST_GAP;
                cnt_n = CNT_W'(BURST_GAP - 1);
            end
            ST_GAP: begin
                if (cnt == '0) st_n = ST_CMD2;
                else cnt_n = cnt - CNT_W'(1);
            end
            ST_CMD2: begin
                st_n = ST_RECOV;
                // tail beat + recovery + precharge, minus the final count cycle
                if (wr_q) cnt_n = CNT_W'(trwl_q) + CNT_W'(TRP);
                else cnt_n = CNT_W'(2 + TRP) + CNT_W'(cl3_q);
            end
            ST_RECOV: begin
                if (cnt == '0) st_n = ST_IDLE;
                else cnt_n = cnt - CNT_W'(1);
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd        = CMD_NOP;
        row_out    = '0;
        col_out    = '0;
        dack       = 1'b0;
        first_cmd  = 1'b0;
        second_cmd = 1'b0;
        req_ready  = 1'b0;
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_PREP: dack = 1'b1;
            ST_ACT: begin
                cmd     = CMD_ACT;
                row_out = row_q;
                dack    = wr_q;
            end
            ST_RCD, ST_GAP, ST_RECOV: cmd = CMD_NOP;
            ST_CMD1: begin
                cmd       = wr_q ? CMD_WR : CMD_RD;
                col_out   = {base_q, crit_q, 3'b000};
                first_cmd = 1'b1;
            end
            ST_CMD2: begin
                cmd        = wr_q ? CMD_WRA : CMD_RDA;
                col_out    = {base_q, ~crit_q[1], 4'b0000};
                second_cmd = 1'b1;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen
    import sdr_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       first_cmd,
    input  logic       second_cmd,
    input  logic [1:0] crit,
    output beat_t      beat
);

    logic       pend_v;
    logic [1:0] pend_unit;
    logic       cmd_now;

    assign cmd_now = first_cmd | second_cmd;

    // second beat of each two-beat half follows one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_unit <= '0;
        end else begin
            pend_v    <= cmd_now;
            pend_unit <= first_cmd ? {crit[1], ~crit[0]} : {~crit[1], 1'b1};
        end
    end

    always_comb begin
        beat.v     = cmd_now | pend_v;
        beat.first = cmd_now;
        if (first_cmd)       beat.unit = crit;
        else if (second_cmd) beat.unit = {~crit[1], 1'b0};
        else                 beat.unit = pend_unit;
    end

endmodule

// File: rtl/sdr_cl_delay.sv
module sdr_cl_delay
    import sdr_line_pkg::*;
#(
    parameter int MAX_CL = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cl3,
    input  beat_t din,
    output beat_t dout
);

    beat_t stage [MAX_CL];

    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else stage[0] <= din;
    end

    for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= '0;
            else stage[i] <= stage[i-1];
        end
    end

    // stage[i] carries a delay of i+1 cycles
    assign dout = cl3 ? stage[2] : stage[1];

endmodule

// File: rtl/sdr_line_seq.sv
module sdr_line_seq
    import sdr_line_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 12,
    parameter int DATA_W = 64,
    parameter int TRP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_rcd,
    input  logic             cfg_cl3,
    input  logic [2:0]       cfg_trwl,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       req_crit,
    output logic [2:0]       sd_cmd,
    output logic [ROW_W-1:0] sd_row,
    output logic [COL_W-1:0] sd_col,
    output logic             dack,
    output logic             wr_beat_valid,
    output logic [1:0]       wr_beat_unit,
    output logic             rd_beat_valid,
    output logic [1:0]       rd_beat_unit,
    output logic             rd_bs
);

    localparam int UNIT_SH  = $clog2(DATA_W / 8);
    localparam int LINE_LSB = UNIT_SH + 2;

    logic       first_cmd, second_cmd, wr_q, cl3_q;
    logic [1:0] crit_q;
    beat_t      issue, rd_in, rd_out;

    sdr_line_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LINE_LSB(LINE_LSB), .TRP(TRP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_crit(req_crit),
        .cfg_rcd(cfg_rcd), .cfg_cl3(cfg_cl3), .cfg_trwl(cfg_trwl),
        .req_ready(req_ready), .cmd(sd_cmd),
        .row_out(sd_row), .col_out(sd_col), .dack(dack),
        .first_cmd(first_cmd), .second_cmd(second_cmd),
        .wr_q(wr_q), .crit_q(crit_q), .cl3_q(cl3_q)
    );

    sdr_beat_gen u_beats (
        .clk(clk), .rst_n(rst_n),
        .first_cmd(first_cmd), .second_cmd(second_cmd),
        .crit(crit_q), .beat(issue)
    );

    always_comb begin
        rd_in   = issue;
        rd_in.v = issue.v & ~wr_q;
    end

    sdr_cl_delay #(.MAX_CL(3)) u_cl (
        .clk(clk), .rst_n(rst_n), .cl3(cl3_q),
        .din(rd_in), .dout(rd_out)
    );

    assign wr_beat_valid = issue.v & wr_q;
    assign wr_beat_unit  = wr_beat_valid ? issue.unit : 2'b00;
    assign rd_beat_valid = rd_out.v;
    assign rd_beat_unit  = rd_out.v ? rd_out.unit : 2'b00;
    assign rd_bs         = rd_out.v & rd_out.first;

endmodule

// File: rtl/sdr_line_seq_chk.sv
module sdr_line_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] sd_cmd,
    input logic       dack,
    input logic       wr_beat_valid,
    input logic       rd_beat_valid,
    input logic       rd_bs
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cmd == 3'd0 && !dack && !wr_beat_valid && !rd_bs));

    p_writa_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd5) |-> ($past(sd_cmd, 4) == 3'd4));

    p_writ_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd4) |=> wr_beat_valid);

    p_dack_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && sd_cmd == 3'd0) |=> (dack && sd_cmd == 3'd1));

    p_dack_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && sd_cmd == 3'd1) |=> (!dack && sd_cmd == 3'd4));

    p_reada_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 3'd3) |-> ($past(sd_cmd, 4) == 3'd2));

    p_bs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bs |=> !rd_bs);

    p_bs_on_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bs |-> (rd_beat_valid && !wr_beat_valid));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

bind sdr_line_seq sdr_line_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .sd_cmd(sd_cmd), .dack(dack), .wr_beat_valid(wr_beat_valid),
    .rd_beat_valid(rd_beat_valid), .rd_bs(rd_bs)
);

// File: tb/sdr_line_seq_test.sv
module sdr_line_seq_test;

    localparam int ROW_W = 13;
    localparam int COL_W = 12;
    localparam int TRP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_rcd = '0;
    logic cfg_cl3 = 1'b0;
    logic [2:0] cfg_trwl = '0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [1:0] req_crit = '0;
    logic req_ready, dack, wr_beat_valid, rd_beat_valid, rd_bs;
    logic [2:0] sd_cmd;
    logic [ROW_W-1:0] sd_row;
    logic [COL_W-1:0] sd_col;
    logic [1:0] wr_beat_unit, rd_beat_unit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdr_line_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_rcd(cfg_rcd), .cfg_cl3(cfg_cl3),
        .cfg_trwl(cfg_trwl), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_crit(req_crit), .sd_cmd(sd_cmd), .sd_row(sd_row), .sd_col(sd_col),
        .dack(dack), .wr_beat_valid(wr_beat_valid), .wr_beat_unit(wr_beat_unit),
        .rd_beat_valid(rd_beat_valid), .rd_beat_unit(rd_beat_unit), .rd_bs(rd_bs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // one line transfer, checked cycle by cycle; inputs scrambled while busy (R10, R11)
    task automatic run(input bit wr, input int crit, input int rcd, input int cl,
                       input int trwl, input int row, input int col);
        int h = crit / 2;
        int c0 = crit % 2;
        int lat = 2 + cl;
        int a = wr ? 2 : 1 + rcd;
        int b = a + 4;
        int dl = wr ? 0 : lat;
        int last = wr ? b + 2 + trwl + TRP : b + lat + 2 + TRP;
        int base = (col / 32) * 32;
        int c1 = base + h * 16 + c0 * 8;
        int c2 = base + (1 - h) * 16;
        int u [4];
        u[0] = crit; u[1] = h * 2 + (1 - c0); u[2] = (1 - h) * 2; u[3] = (1 - h) * 2 + 1;
        req_valid = 1'b1; req_write = wr; req_crit = 2'(crit);
        req_row = ROW_W'(row); req_col = COL_W'(col);
        cfg_rcd = 2'(rcd); cfg_cl3 = cl[0]; cfg_trwl = 3'(trwl);
        @(negedge clk);
        for (int k = 0; k <= last; k++) begin
            int ecmd = 0;
            int bi = -1;
            if (wr) begin
                if (k == 1) ecmd = 1;
                if (k == a) ecmd = 4;
                if (k == b) ecmd = 5;
            end else begin
                if (k == 0) ecmd = 1;
                if (k == a) ecmd = 2;
                if (k == b) ecmd = 3;
            end
            if (k == a + dl) bi = 0;
            if (k == a + dl + 1) bi = 1;
            if (k == b + dl) bi = 2;
            if (k == b + dl + 1) bi = 3;
            chk(wr ? "R2 cmd" : "R5 cmd", int'(sd_cmd), ecmd);
            if (ecmd == 1) chk(wr ? "R2 row" : "R5 row", int'(sd_row), row);
            if (k == a) chk(wr ? "R2 col1" : "R5 col1", int'(sd_col), c1);
            if (k == b) chk(wr ? "R2 col2" : "R5 col2", int'(sd_col), c2);
            chk("R4 dack", int'(dack), (wr && k <= 1) ? 1 : 0);
            chk("R3 wr_valid", int'(wr_beat_valid), (wr && bi >= 0) ? 1 : 0);
            chk("R6 rd_valid", int'(rd_beat_valid), (!wr && bi >= 0) ? 1 : 0);
            if (bi >= 0) chk(wr ? "R3 wr_unit" : "R6 rd_unit",
                             wr ? int'(wr_beat_unit) : int'(rd_beat_unit), u[bi]);
            chk("R7 bs", int'(rd_bs), (!wr && (bi == 0 || bi == 2)) ? 1 : 0);
            if (k < last) chk("R10 busy", int'(req_ready), 0);
            else chk(wr ? "R8 R11 ready" : "R9 R11 ready", int'(req_ready), 1);
            if (k == last) break;
            if (k + 1 == last) begin
                req_valid = 1'b0;
            end else begin
                req_valid = 1'b1; req_write = ~wr; req_crit = ~req_crit;
                req_row = ~req_row; req_col = req_col + COL_W'(96);
                cfg_rcd = cfg_rcd + 2'd1; cfg_cl3 = ~cfg_cl3; cfg_trwl = cfg_trwl + 3'd3;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 cmd", int'(sd_cmd), 0);
        chk("R1 dack", int'(dack), 0);
        chk("R1 bs", int'(rd_bs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 cmd", int'(sd_cmd), 0);
        chk("R1 beats", int'(wr_beat_valid | rd_beat_valid), 0);
        for (int crit = 0; crit < 4; crit++)
            for (int trwl = 0; trwl < 8; trwl++)
                run(1'b1, crit, 0, 0, trwl, crit * 1000 + trwl * 7, crit * 300 + trwl * 41 + 5);
        for (int crit = 0; crit < 4; crit++)
            for (int rcd = 0; rcd < 4; rcd++)
                for (int cl = 0; cl < 2; cl++)
                    run(1'b0, crit, rcd, cl, 0, 4000 + crit * 97 + rcd * 13 + cl,
                        crit * 517 + rcd * 71 + cl * 33 + 17);
        // idle with no request: nothing issued (R1)
        repeat (3) begin
            @(negedge clk);
            chk("R1 idle cmd", int'(sd_cmd), 0);
            chk("R1 idle ready", int'(req_ready), 1);
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule